// File: doc/BRIEF.md
# Segmented Address and Stack Pointer Unit

This block turns segment:offset pairs into 20-bit physical addresses for a 16-bit processor core. A data reference supplies an offset and a code for the register the offset was built from. The unit picks the default segment from that code: the base-pointer register goes with the stack segment, and every other source goes with the data segment. An explicit override on the request selects any of the four segment registers instead. The physical address is the segment value shifted left by four bits plus the offset, truncated to 20 bits.

The unit also holds the instruction pointer and the stack pointer. The fetch address is always the code segment joined with the instruction pointer. After each fetch the pointer advances by the length of the instruction that was read. A push or a pop of byte or word size moves the stack pointer by one or two. A push presents the decremented pointer as the write address. A pop presents the current pointer as the read address. Neither pointer is checked against a limit, and both wrap modulo 2^16.

Top module: `seg_addr_unit`

## Requirements
- R1: Every physical address output equals (segment << 4) + offset, taken modulo 2^20, so a sum past 0xFFFFF wraps to the low end.
- R2: Without an override, an offset source code of 0 (direct), 1 (BX), 2 (SI), 3 (DI), or any code of 5 to 7, addresses through the data segment on `seg_ds`.
- R3: Without an override, source code 4 (BP) addresses through the stack segment on `seg_ss`.
- R4: When `ovr_en` is high, `ovr_seg` picks the segment in place of the default: 0 = `seg_es`, 1 = `seg_cs`, 2 = `seg_ss`, 3 = `seg_ds`.
- R5: `fetch_pa` is always the address formed from `seg_cs` and the instruction pointer, and the pointer holds IP_RST after reset.
- R6: When `fetch_en` is high at a clock edge, the instruction pointer increases by `fetch_len` at that edge and wraps modulo 2^16. Without `fetch_en` it holds.
- R7: A push (`stk_push`) decrements the stack pointer at the clock edge by 2 when `stk_word` is 1 and by 1 when it is 0. In the same cycle `stk_pa` shows the stack segment joined with the decremented value.
- R8: A pop (`stk_pop` without `stk_push`) presents the stack segment joined with the current stack pointer on `stk_pa`, and increments the pointer at the clock edge by 2 for a word or 1 for a byte.
- R9: The stack pointer resets to SP_RST and wraps freely modulo 2^16 in both directions, with no limit check.
- R10: If push and pop are requested in the same cycle, only the push is carried out and the pop has no effect.
- R11: With neither push nor pop, the stack pointer holds and `stk_pa` shows the stack segment joined with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_es | input | SEG_W | Extra segment value |
| seg_cs | input | SEG_W | Code segment value |
| seg_ss | input | SEG_W | Stack segment value |
| seg_ds | input | SEG_W | Data segment value |
| mem_off | input | OFF_W | Data reference offset |
| ofs_base | input | 3 | Register the offset was built from (code per R2/R3) |
| ovr_en | input | 1 | Explicit segment override present |
| ovr_seg | input | 2 | Override segment code (per R4) |
| data_pa | output | PA_W | Data reference physical address |
| fetch_en | input | 1 | An instruction is fetched this cycle |
| fetch_len | input | LEN_W | Byte length of the fetched instruction |
| ip_val | output | OFF_W | Current instruction pointer |
| fetch_pa | output | PA_W | Instruction fetch physical address |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_word | input | 1 | 1 = word operand, 0 = byte operand |
| sp_val | output | OFF_W | Current stack pointer |
| stk_pa | output | PA_W | Stack access physical address |

## Verification
The bench keeps the default widths (16-bit segments and offsets, 20-bit address, shift of 4). It sets SP_RST to 0x0001 and IP_RST to 0xFFFC. With these reset values, the first word push wraps the stack pointer below zero, and the first six-byte fetch wraps the instruction pointer past 0xFFFF. Both wraps happen within a few cycles. Segment values of 0xFFFF are combined with large offsets to push the address sum past 20 bits.

// File: rtl/seg_addr_pkg.sv
// Shared codes for the segmented address unit: offset source registers
// and segment register identifiers as they appear on the ports.
package seg_addr_pkg;

    // Register the data offset was formed from; selects the default segment.
    typedef enum logic [2:0] {
        OFS_DIRECT = 3'd0,
        OFS_BX     = 3'd1,
        OFS_SI     = 3'd2,
        OFS_DI     = 3'd3,
        OFS_BP     = 3'd4
    } ofs_base_e;

    // Segment register identifiers used by the override field.
    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

endpackage

// File: rtl/seg_pick.sv
// Chooses which segment register qualifies a data reference.
// The default follows the offset source register (base pointer -> stack
// segment, all others -> data segment). An explicit override wins.
// Purely combinational.
module seg_pick
    import seg_addr_pkg::*;
(
    input  logic [2:0] ofs_base,
    input  logic       ovr_en,
    input  logic [1:0] ovr_seg,
    output seg_id_e    pick
);

    seg_id_e dflt;

    // Default segment from the offset source register.
    always_comb begin
        case (ofs_base_e'(ofs_base))
            OFS_BP:  dflt = SEG_SS;
            default: dflt = SEG_DS;
        endcase
    end

    // An override replaces the default outright.
    always_comb begin
        pick = ovr_en ? seg_id_e'(ovr_seg) : dflt;
    end

endmodule

// File: rtl/phys_addr.sv
// Forms a physical address from a segment and an offset: the segment is
// shifted left by SHIFT bits, the offset is added, and the sum is kept to
// PA_W bits so a carry out of the top is dropped.
module phys_addr #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);

    logic [PA_W-1:0] seg_ext;
    logic [PA_W-1:0] off_ext;

    // Widen both operands to the address width and add.
    always_comb begin
        seg_ext = PA_W'(seg) << SHIFT;
        off_ext = PA_W'(off);
        pa      = seg_ext + off_ext;
    end

endmodule

// File: rtl/ip_ctr.sv
// Instruction pointer register. It advances by the fetched instruction
// length on each fetch and wraps modulo 2^W. It assumes the length input is
// valid whenever fetch_en is high.
module ip_ctr #(
    parameter int             W     = 16,
    parameter int             LEN_W = 3,
    parameter logic [W-1:0]   RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_en,
    input  logic [LEN_W-1:0] fetch_len,
    output logic [W-1:0]     ip
);

    // Step the pointer past each fetched instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip <= RST;
        else if (fetch_en)
            ip <= ip + W'(fetch_len);
    end

endmodule

// File: rtl/stack_ptr.sv
// Stack pointer register with byte/word push and pop. A push takes
// priority over a pop requested in the same cycle. No limit check; the
// pointer wraps modulo 2^W. top_off is the offset of the current stack
// access: the decremented value for a push, else the current value.
module stack_ptr #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         word,
    output logic [W-1:0] sp,
    output logic [W-1:0] top_off
);

    localparam logic [W-1:0] STEP_BYTE = W'(1);
    localparam logic [W-1:0] STEP_WORD = W'(2);

    logic [W-1:0] step;
    logic [W-1:0] sp_dn;
    logic [W-1:0] sp_up;

    // Candidate next values and the offset shown for the current access.
    always_comb begin
        step    = word ? STEP_WORD : STEP_BYTE;
        sp_dn   = sp - step;
        sp_up   = sp + step;
        top_off = push ? sp_dn : sp;
    end

    // Commit at most one stack operation per cycle, push first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= RST;
        else if (push)
            sp <= sp_dn;
        else if (pop)
            sp <= sp_up;
    end

endmodule

// File: rtl/seg_addr_unit.sv
// Segmented address and stack pointer unit. It produces three physical
// addresses (data reference, instruction fetch, stack access) from the
// segment registers and the offsets, and it owns the instruction and stack
// pointers. Segment values come from outside and are assumed stable for the
// cycle in which they are used. Memory and decode are outside this block.
module seg_addr_unit
    import seg_addr_pkg::*;
#(
    parameter int                 SEG_W  = 16,
    parameter int                 OFF_W  = 16,
    parameter int                 PA_W   = 20,
    parameter int                 SHIFT  = 4,
    parameter int                 LEN_W  = 3,
    parameter logic [OFF_W-1:0]   SP_RST = '0,
    parameter logic [OFF_W-1:0]   IP_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_es,
    input  logic [SEG_W-1:0] seg_cs,
    input  logic [SEG_W-1:0] seg_ss,
    input  logic [SEG_W-1:0] seg_ds,
    input  logic [OFF_W-1:0] mem_off,
    input  logic [2:0]       ofs_base,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    output logic [PA_W-1:0]  data_pa,
    input  logic             fetch_en,
    input  logic [LEN_W-1:0] fetch_len,
    output logic [OFF_W-1:0] ip_val,
    output logic [PA_W-1:0]  fetch_pa,
    input  logic             stk_push,
    input  logic             stk_pop,
    input  logic             stk_word,
    output logic [OFF_W-1:0] sp_val,
    output logic [PA_W-1:0]  stk_pa
);

    localparam int NUM_PATHS = 3;
    localparam int P_DATA    = 0;
    localparam int P_FETCH   = 1;
    localparam int P_STACK   = 2;

    seg_id_e          pick;
    logic [SEG_W-1:0] data_seg;
    logic [OFF_W-1:0] stk_off;

    logic [SEG_W-1:0] path_seg [NUM_PATHS];
    logic [OFF_W-1:0] path_off [NUM_PATHS];
    logic [PA_W-1:0]  path_pa  [NUM_PATHS];

    seg_pick u_pick (
        .ofs_base (ofs_base),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_seg),
        .pick     (pick)
    );

    // Route the chosen segment register value to the data path.
    always_comb begin
        case (pick)
            SEG_ES:  data_seg = seg_es;
            SEG_CS:  data_seg = seg_cs;
            SEG_SS:  data_seg = seg_ss;
            default: data_seg = seg_ds;
        endcase
    end

    ip_ctr #(
        .W     (OFF_W),
        .LEN_W (LEN_W),
        .RST   (IP_RST)
    ) u_ip (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (fetch_en),
        .fetch_len (fetch_len),
        .ip        (ip_val)
    );

    stack_ptr #(
        .W   (OFF_W),
        .RST (SP_RST)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (stk_push),
        .pop     (stk_pop),
        .word    (stk_word),
        .sp      (sp_val),
        .top_off (stk_off)
    );

    // Segment and offset for each address path.
    assign path_seg[P_DATA]  = data_seg;
    assign path_off[P_DATA]  = mem_off;
    assign path_seg[P_FETCH] = seg_cs;
    assign path_off[P_FETCH] = ip_val;
    assign path_seg[P_STACK] = seg_ss;
    assign path_off[P_STACK] = stk_off;

    // One adder per address path.
    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_pa
        phys_addr #(
            .SEG_W (SEG_W),
            .OFF_W (OFF_W),
            .PA_W  (PA_W),
            .SHIFT (SHIFT)
        ) u_pa (
            .seg (path_seg[g]),
            .off (path_off[g]),
            .pa  (path_pa[g])
        );
    end

    assign data_pa  = path_pa[P_DATA];
    assign fetch_pa = path_pa[P_FETCH];
    assign stk_pa   = path_pa[P_STACK];

endmodule

// File: rtl/seg_addr_unit_chk.sv
// Property checker for seg_addr_unit, attached by bind. It relates the
// address outputs to the segment inputs and follows pointer motion across
// clock edges.
module seg_addr_unit_chk #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4,
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEG_W-1:0] seg_es,
    input logic [SEG_W-1:0] seg_cs,
    input logic [SEG_W-1:0] seg_ss,
    input logic [SEG_W-1:0] seg_ds,
    input logic [OFF_W-1:0] mem_off,
    input logic [2:0]       ofs_base,
    input logic             ovr_en,
    input logic [1:0]       ovr_seg,
    input logic [PA_W-1:0]  data_pa,
    input logic             fetch_en,
    input logic [LEN_W-1:0] fetch_len,
    input logic [OFF_W-1:0] ip_val,
    input logic [PA_W-1:0]  fetch_pa,
    input logic             stk_push,
    input logic             stk_pop,
    input logic             stk_word,
    input logic [OFF_W-1:0] sp_val,
    input logic [PA_W-1:0]  stk_pa
);

    function automatic logic [PA_W-1:0] join_pa(logic [SEG_W-1:0] s, logic [OFF_W-1:0] o);
        return (PA_W'(s) << SHIFT) + PA_W'(o);
    endfunction

    logic [OFF_W-1:0] step;
    assign step = stk_word ? OFF_W'(2) : OFF_W'(1);

    // R3
    bp_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_base == 3'd4 && !ovr_en) |-> data_pa == join_pa(seg_ss, mem_off));

    // R2
    ds_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_base != 3'd4 && !ovr_en) |-> data_pa == join_pa(seg_ds, mem_off));

    // R4
    es_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && ovr_seg == 2'd0) |-> data_pa == join_pa(seg_es, mem_off));

    // R5
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pa == join_pa(seg_cs, ip_val));

    // R6
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> ip_val == $past(ip_val) + OFF_W'($past(fetch_len)));

    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> sp_val == $past(sp_val) - $past(step));

    // R7
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> stk_pa == join_pa(seg_ss, sp_val - step));

    // R8
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_pop && !stk_push) |=> sp_val == $past(sp_val) + $past(step));

    // R11
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_pop && !stk_push) |=> $stable(sp_val));

endmodule

bind seg_addr_unit seg_addr_unit_chk #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W),
    .SHIFT (SHIFT),
    .LEN_W (LEN_W)
) chk (.*);

// File: tb/seg_addr_unit_test.sv
// Directed bench for seg_addr_unit: one task per scenario.
module seg_addr_unit_test;

    localparam logic [15:0] SP_START = 16'h0001;
    localparam logic [15:0] IP_START = 16'hFFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic [15:0] mem_off = '0;
    logic [2:0]  ofs_base = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [19:0] data_pa;
    logic        fetch_en = 1'b0;
    logic [2:0]  fetch_len = '0;
    logic [15:0] ip_val;
    logic [19:0] fetch_pa;
    logic        stk_push = 1'b0, stk_pop = 1'b0, stk_word = 1'b0;
    logic [15:0] sp_val;
    logic [19:0] stk_pa;

    int checks = 0;
    int errors = 0;

    seg_addr_unit #(
        .SP_RST (SP_START),
        .IP_RST (IP_START)
    ) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [19:0] pa(logic [15:0] s, logic [15:0] o);
        return ({4'h0, s} << 4) + {4'h0, o};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Present a data reference and compare the address in the same cycle.
    task automatic data_ref(logic [2:0] b, logic oe, logic [1:0] os,
                            logic [15:0] o, logic [19:0] exp, string req);
        @(negedge clk);
        ofs_base = b; ovr_en = oe; ovr_seg = os; mem_off = o;
        #1 check(req, 32'(data_pa), 32'(exp));
    endtask

    // One stack cycle: check the access address, then the pointer after the edge.
    task automatic stack_op(logic pu, logic po, logic w,
                            logic [19:0] exp_pa, logic [15:0] exp_sp, string req);
        @(negedge clk);
        stk_push = pu; stk_pop = po; stk_word = w;
        #1 check(req, 32'(stk_pa), 32'(exp_pa));
        @(negedge clk);
        stk_push = 1'b0; stk_pop = 1'b0;
        check(req, 32'(sp_val), 32'(exp_sp));
    endtask

    task automatic t_reset();
        check("R9 sp reset", 32'(sp_val), 32'(SP_START));
        check("R5 ip reset", 32'(ip_val), 32'(IP_START));
        check("R5 fetch at reset", 32'(fetch_pa), 32'(pa(seg_cs, IP_START)));
    endtask

    task automatic t_defaults();
        seg_ds = 16'h1234; seg_ss = 16'h5000; seg_es = 16'h2000; seg_cs = 16'h0F00;
        data_ref(3'd0, 1'b0, 2'd0, 16'h0056, 20'h12396, "R2 direct");
        data_ref(3'd1, 1'b0, 2'd0, 16'h0056, 20'h12396, "R2 BX");
        data_ref(3'd2, 1'b0, 2'd0, 16'h0100, 20'h12440, "R2 SI");
        data_ref(3'd3, 1'b0, 2'd0, 16'h0001, 20'h12341, "R2 DI");
        data_ref(3'd6, 1'b0, 2'd0, 16'h0001, 20'h12341, "R2 spare code");
        data_ref(3'd4, 1'b0, 2'd0, 16'h0056, 20'h50056, "R3 BP");
    endtask

    task automatic t_override();
        data_ref(3'd4, 1'b1, 2'd0, 16'h0056, 20'h20056, "R4 BP over ES");
        data_ref(3'd1, 1'b1, 2'd2, 16'h0056, 20'h50056, "R4 BX over SS");
        data_ref(3'd2, 1'b1, 2'd1, 16'h0056, 20'h0F056, "R4 SI over CS");
        data_ref(3'd4, 1'b1, 2'd3, 16'h0056, 20'h12396, "R4 BP over DS");
    endtask

    task automatic t_addr_wrap();
        seg_ds = 16'hA000;
        data_ref(3'd0, 1'b0, 2'd0, 16'h1234, 20'hA1234, "R1 plain sum");
        seg_ds = 16'hFFFF;
        data_ref(3'd0, 1'b0, 2'd0, 16'h0010, 20'h00000, "R1 wrap to zero");
        data_ref(3'd1, 1'b0, 2'd0, 16'hFFFF, 20'h0FFEF, "R1 wrap high");
        seg_ds = 16'h1234;
    endtask

    task automatic t_fetch();
        @(negedge clk);
        fetch_en = 1'b1; fetch_len = 3'd6;
        #1 check("R5 fetch addr", 32'(fetch_pa), 32'(pa(16'h0F00, 16'hFFFC)));
        @(negedge clk);
        check("R6 ip wrap", 32'(ip_val), 32'h0002);
        fetch_len = 3'd1;
        @(negedge clk);
        fetch_en = 1'b0;
        check("R6 ip step 1", 32'(ip_val), 32'h0003);
        check("R5 fetch addr", 32'(fetch_pa), 32'(pa(16'h0F00, 16'h0003)));
        @(negedge clk);
        check("R6 ip hold", 32'(ip_val), 32'h0003);
    endtask

    task automatic t_stack();
        seg_ss = 16'h5000;
        stack_op(1'b1, 1'b0, 1'b1, 20'h5FFFF, 16'hFFFF, "R7 R9 word push wrap");
        stack_op(1'b1, 1'b0, 1'b0, 20'h5FFFE, 16'hFFFE, "R7 byte push");
        stack_op(1'b0, 1'b1, 1'b1, 20'h5FFFE, 16'h0000, "R8 R9 word pop wrap");
        stack_op(1'b0, 1'b1, 1'b0, 20'h50000, 16'h0001, "R8 byte pop");
        stack_op(1'b1, 1'b1, 1'b1, 20'h5FFFF, 16'hFFFF, "R10 push beats pop");
        stack_op(1'b0, 1'b0, 1'b1, 20'h5FFFF, 16'hFFFF, "R11 idle");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seg_cs = 16'h0F00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_defaults();
        t_override();
        t_addr_wrap();
        t_fetch();
        t_stack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule